// File: doc/BRIEF.md
# Lockable Shadowed PWM Channel

A single-channel pulse-width modulator driven by a small word-indexed register bus with separate write and read strobes. A free-running counter steps once per clock from zero up to one less than the programmed period and then wraps. The output sits at a programmable duty level while the count is below the duty value and at a programmable inactive level for the rest of the period. The duty portion always starts at count zero (left-aligned).

Software never writes the values that shape the waveform directly. Period, duty and the two output levels are written into shadow registers. They are copied into the active set only when a period ends, or when the channel starts from the stopped state. A lock bit in the control word holds the active set frozen. Software can set the lock, rewrite period, duty and levels in any order, and then clear the lock. The whole new configuration then takes effect at the next wrap, and no mixed period is ever produced.

Top module: `lpwm_channel`

## Requirements
- R1: After reset, reads of all four registers return 0 and `pwm_out` is 0.
- R2: Register index 0 (byte offset 0x0) is the counter, 1 (0x4) the period, 2 (0x8) the duty and 3 (0xC) the control word. `rdata` is loaded on the clock edge where `rd_en` is high. Period and duty reads return the shadow values. A control read returns only bits 0, 1, 3, 4, 5 and 6, with all other bits 0.
- R3: The channel runs only when control bit 0 (enable) and bit 1 (continuous) are both 1. Otherwise the counter reads 0 and `pwm_out` equals control bit 4.
- R4: While running, the counter advances by one on every clock and wraps from period-1 to 0. A period of 0 or 1 keeps the counter at 0.
- R5: While running, `pwm_out` equals the duty level (control bit 3) when count < duty and the inactive level (control bit 4) otherwise. A duty of 0 therefore gives a constant inactive level, and a duty at or above the period gives a constant duty level.
- R6: Setting both run bits from the stopped state copies the shadow period, duty and levels into the active set. The counter starts at 0 one clock after the control write edge.
- R7: While control bit 6 (lock) is 1, the active period, duty and levels stay unchanged, across any number of wraps.
- R8: When the lock is cleared, all held period, duty and level changes take effect together at the next wrap.
- R9: With the lock clear, a shadow write during a period does not change the waveform before the next wrap.
- R10: Writes to the counter index change no register. A counter read returns the live count.
- R11: Clearing a run bit stops the channel one clock after the write edge, with the counter at 0 and the inactive level driven.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 2 | Register word index |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, registered |
| pwm_out | output | 1 | Modulated output |

## Verification
On every cycle, the assertions check the counter's stepping and range, that a stop request leaves the counter at zero, and that the active set is frozen under the lock and between wraps. They also check that counter-index writes leave the shadow registers alone. What the assertions cannot see is the waveform itself. The bench scenarios show the exact output against the count for many random period, duty and level choices, and that a locked multi-register update appears in full only after unlock. They also cover readback masking and the one-clock start and stop latency.

// File: rtl/lpwm_pkg.sv
// Shared constants and types for the lockable shadowed PWM channel.
// Assumes a four-word register window and a fixed control bit layout.
package lpwm_pkg;
    localparam int IDX_W = 2;

    localparam logic [IDX_W-1:0] IDX_COUNT  = 2'd0;
    localparam logic [IDX_W-1:0] IDX_PERIOD = 2'd1;
    localparam logic [IDX_W-1:0] IDX_DUTY   = 2'd2;
    localparam logic [IDX_W-1:0] IDX_CTRL   = 2'd3;

    localparam int CB_EN    = 0;
    localparam int CB_CONT  = 1;
    localparam int CB_DLVL  = 3;
    localparam int CB_ILVL  = 4;
    localparam int CB_ALIGN = 5;
    localparam int CB_LOCK  = 6;

    // Output levels that travel together through the shadow/active path.
    typedef struct packed {
        logic duty_lvl;
        logic idle_lvl;
    } lvl_t;

    // Decoded control word.
    typedef struct packed {
        logic lock;
        logic align;
        logic idle_lvl;
        logic duty_lvl;
        logic cont;
        logic en;
    } ctrl_t;
endpackage

// File: rtl/lpwm_regfile.sv
// Register window: holds the shadow period, duty and control word and
// serves registered reads. Assumes at most one access per cycle;
// writes to the counter index are dropped.
module lpwm_regfile
    import lpwm_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [IDX_W-1:0]  addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] live_cnt,
    output logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] sh_period,
    output logic [DATA_W-1:0] sh_duty,
    output ctrl_t             sh_ctrl
);
    logic [DATA_W-1:0] rd_mux;

    // Capture software writes into the shadow registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_period <= '0;
            sh_duty   <= '0;
            sh_ctrl   <= '0;
        end else if (wr_en) begin
            case (addr)
                IDX_PERIOD: sh_period <= wdata;
                IDX_DUTY:   sh_duty   <= wdata;
                IDX_CTRL: begin
                    sh_ctrl.en       <= wdata[CB_EN];
                    sh_ctrl.cont     <= wdata[CB_CONT];
                    sh_ctrl.duty_lvl <= wdata[CB_DLVL];
                    sh_ctrl.idle_lvl <= wdata[CB_ILVL];
                    sh_ctrl.align    <= wdata[CB_ALIGN];
                    sh_ctrl.lock     <= wdata[CB_LOCK];
                end
                default: ;
            endcase
        end
    end

    // Select the word addressed by a read.
    always_comb begin
        rd_mux = '0;
        case (addr)
            IDX_COUNT:  rd_mux = live_cnt;
            IDX_PERIOD: rd_mux = sh_period;
            IDX_DUTY:   rd_mux = sh_duty;
            default: begin
                rd_mux[CB_EN]    = sh_ctrl.en;
                rd_mux[CB_CONT]  = sh_ctrl.cont;
                rd_mux[CB_DLVL]  = sh_ctrl.duty_lvl;
                rd_mux[CB_ILVL]  = sh_ctrl.idle_lvl;
                rd_mux[CB_ALIGN] = sh_ctrl.align;
                rd_mux[CB_LOCK]  = sh_ctrl.lock;
            end
        endcase
    end

    // Register the read data on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)     rdata <= '0;
        else if (rd_en) rdata <= rd_mux;
    end

    // R10
    cnt_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == IDX_COUNT) |=>
            ($stable(sh_period) && $stable(sh_duty) && $stable(sh_ctrl)));
endmodule

// File: rtl/lpwm_timer.sv
// Period timer with the active configuration set. Loads the shadow set
// while stopped and at unlocked wraps; steps the counter while running.
// Assumes run_cfg and lock come straight from the shadow control word.
module lpwm_timer
    import lpwm_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_cfg,
    input  logic              lock,
    input  logic [DATA_W-1:0] sh_period,
    input  logic [DATA_W-1:0] sh_duty,
    input  lvl_t              sh_lvl,
    output logic              running,
    output logic [DATA_W-1:0] cnt,
    output logic [DATA_W-1:0] act_duty,
    output lvl_t              act_lvl
);
    localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

    logic [DATA_W-1:0] act_period;
    logic              wrap_now;
    logic              commit;

    // Detect the last count of the active period.
    always_comb begin
        wrap_now = (act_period <= ONE) || (cnt == act_period - ONE);
        commit   = !running || (run_cfg && wrap_now && !lock);
    end

    // Transfer the shadow set into the active set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_period <= '0;
            act_duty   <= '0;
            act_lvl    <= '0;
        end else if (commit) begin
            act_period <= sh_period;
            act_duty   <= sh_duty;
            act_lvl    <= sh_lvl;
        end
    end

    // Track the run state and step or clear the counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running <= 1'b0;
            cnt     <= '0;
        end else if (!running) begin
            running <= run_cfg;
            cnt     <= '0;
        end else if (!run_cfg) begin
            running <= 1'b0;
            cnt     <= '0;
        end else if (wrap_now) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + ONE;
        end
    end

    // R4
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (running && act_period > ONE) |-> (cnt < act_period));

    // R4
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (running && run_cfg && !wrap_now) |=> (cnt == $past(cnt) + ONE));

    // R3
    stop_cnt_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_cfg |=> (cnt == '0));

    // R7
    lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (running && run_cfg && lock) |=>
            ($stable(act_period) && $stable(act_duty) && $stable(act_lvl)));

    // R9
    midperiod_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (running && run_cfg && !wrap_now) |=>
            ($stable(act_period) && $stable(act_duty) && $stable(act_lvl)));
endmodule

// File: rtl/lpwm_wavegen.sv
// Output stage: left-aligned compare of the count against the active duty.
// Drives the shadow inactive level whenever the timer is stopped.
module lpwm_wavegen
    import lpwm_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              running,
    input  logic [DATA_W-1:0] cnt,
    input  logic [DATA_W-1:0] act_duty,
    input  lvl_t              act_lvl,
    input  logic              stop_lvl,
    output logic              pwm_out
);
    // Choose the level for the current count.
    always_comb begin
        if (!running)            pwm_out = stop_lvl;
        else if (cnt < act_duty) pwm_out = act_lvl.duty_lvl;
        else                     pwm_out = act_lvl.idle_lvl;
    end
endmodule

// File: rtl/lpwm_channel.sv
// Top of the lockable shadowed PWM channel: register window, period timer
// with active set, and output stage. Assumes one bus access per cycle.
module lpwm_channel
    import lpwm_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic                    rd_en,
    input  logic [IDX_W-1:0]        addr,
    input  logic [DATA_W-1:0]       wdata,
    output logic [DATA_W-1:0]       rdata,
    output logic                    pwm_out
);
    logic [DATA_W-1:0] sh_period;
    logic [DATA_W-1:0] sh_duty;
    ctrl_t             sh_ctrl;
    lvl_t              sh_lvl;
    logic              run_cfg;
    logic              running;
    logic [DATA_W-1:0] cnt;
    logic [DATA_W-1:0] act_duty;
    lvl_t              act_lvl;

    // Derive the run request and level pair from the shadow control word.
    always_comb begin
        run_cfg         = sh_ctrl.en && sh_ctrl.cont;
        sh_lvl.duty_lvl = sh_ctrl.duty_lvl;
        sh_lvl.idle_lvl = sh_ctrl.idle_lvl;
    end

    lpwm_regfile #(.DATA_W(DATA_W)) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .rd_en     (rd_en),
        .addr      (addr),
        .wdata     (wdata),
        .live_cnt  (cnt),
        .rdata     (rdata),
        .sh_period (sh_period),
        .sh_duty   (sh_duty),
        .sh_ctrl   (sh_ctrl)
    );

    lpwm_timer #(.DATA_W(DATA_W)) timer_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_cfg   (run_cfg),
        .lock      (sh_ctrl.lock),
        .sh_period (sh_period),
        .sh_duty   (sh_duty),
        .sh_lvl    (sh_lvl),
        .running   (running),
        .cnt       (cnt),
        .act_duty  (act_duty),
        .act_lvl   (act_lvl)
    );

    lpwm_wavegen #(.DATA_W(DATA_W)) wave_i (
        .running  (running),
        .cnt      (cnt),
        .act_duty (act_duty),
        .act_lvl  (act_lvl),
        .stop_lvl (sh_ctrl.idle_lvl),
        .pwm_out  (pwm_out)
    );
endmodule

// File: tb/lpwm_channel_tb_top.sv
// Bench for lpwm_channel: random period/duty/level runs plus directed
// lock, mid-period write, counter access and stop cases.
module lpwm_channel_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [1:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        pwm_out;

    int n_tests = 0;
    int n_fail  = 0;

    always #2 clk = ~clk;

    lpwm_channel dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .pwm_out(pwm_out)
    );

    function automatic logic [31:0] ctrl_word(logic en, logic cont, logic dl,
                                              logic il, logic lk);
        return (32'(en) << 0) | (32'(cont) << 1) | (32'(dl) << 3) |
               (32'(il) << 4) | (32'(lk) << 6);
    endfunction

    function automatic int exp_cnt(int j, int p);
        return (p <= 1) ? 0 : (j % p);
    endfunction

    function automatic logic exp_level(int c, int d, logic dl, logic il);
        return (c < d) ? dl : il;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] idx, logic [31:0] v);
        @(negedge clk);
        wr_en = 1'b1; addr = idx; wdata = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [1:0] idx, output logic [31:0] v);
        @(negedge clk);
        rd_en = 1'b1; addr = idx;
        @(negedge clk);
        rd_en = 1'b0;
        v = rdata;
    endtask

    task automatic count_ones(int n, output int ones);
        ones = 0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            ones += int'(pwm_out);
        end
    endtask

    // Stop, program, start, then compare each cycle against the count.
    task automatic start_and_check(int p, int d, logic dl, logic il, int ncyc);
        wr(2'd3, ctrl_word(1'b0, 1'b0, 1'b0, il, 1'b0));
        repeat (2) @(negedge clk);
        chk("R3 stopped level", 32'(pwm_out), 32'(il));
        wr(2'd1, 32'(p));
        wr(2'd2, 32'(d));
        wr(2'd3, ctrl_word(1'b1, 1'b1, dl, il, 1'b0));
        chk("R6 level before start", 32'(pwm_out), 32'(il));
        for (int j = 0; j < ncyc; j++) begin
            @(negedge clk);
            chk("R5/R6 waveform", 32'(pwm_out),
                32'(exp_level(exp_cnt(j, p), d, dl, il)));
        end
    endtask

    initial begin
        #(4 * 150000);
        n_fail++;
        $display("FAIL watchdog (all): actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v, a, b;
        int ones, p, d;
        logic dl, il;
        v = $urandom(32'd4321);

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk("R1 output", 32'(pwm_out), 32'h0);
        for (int i = 0; i < 4; i++) begin
            rd(2'(i), v);
            chk("R1 readback", v, 32'h0);
        end

        // R2 shadow readback and control masking
        wr(2'd1, 32'hDEADBEEF); rd(2'd1, v); chk("R2 period", v, 32'hDEADBEEF);
        wr(2'd2, 32'h12345678); rd(2'd2, v); chk("R2 duty", v, 32'h12345678);
        wr(2'd3, 32'h00000078); rd(2'd3, v); chk("R2 ctrl bits", v, 32'h78);
        wr(2'd3, 32'hFFFFFF84); rd(2'd3, v); chk("R2 ctrl mask", v, 32'h0);

        // R3 one run bit alone does not start the channel
        wr(2'd1, 32'd5); wr(2'd2, 32'd2);
        wr(2'd3, ctrl_word(1'b1, 1'b0, 1'b1, 1'b0, 1'b0));
        for (int k = 0; k < 6; k++) begin
            @(negedge clk); chk("R3 enable only", 32'(pwm_out), 32'h0);
        end
        rd(2'd0, v); chk("R3 counter held", v, 32'h0);
        wr(2'd3, ctrl_word(1'b0, 1'b1, 1'b0, 1'b1, 1'b0));
        for (int k = 0; k < 6; k++) begin
            @(negedge clk); chk("R3 continuous only", 32'(pwm_out), 32'h1);
        end

        // R4 R5 R6 random configurations
        for (int it = 0; it < 12; it++) begin
            p  = 2 + int'($urandom % 14);
            d  = int'($urandom % 32'(p + 3));
            dl = 1'($urandom);
            il = 1'($urandom);
            start_and_check(p, d, dl, il, 2 * p + 1);
        end

        // R5 corner cases: zero duty, full duty, tiny periods (R4)
        start_and_check(9, 0, 1'b1, 1'b0, 18);
        start_and_check(9, 9, 1'b1, 1'b0, 18);
        start_and_check(1, 1, 1'b0, 1'b1, 6);
        start_and_check(0, 0, 1'b1, 1'b0, 6);

        // R10 live counter reads and ignored counter writes
        start_and_check(7, 3, 1'b1, 1'b0, 4);
        rd(2'd0, a); rd(2'd0, b);
        chk("R10 live count", b, (a + 32'd2) % 32'd7);
        wr(2'd0, 32'h5);
        rd(2'd1, v); chk("R10 period kept", v, 32'd7);
        rd(2'd2, v); chk("R10 duty kept", v, 32'd3);
        rd(2'd0, v); chk("R4 count in range", 32'(v < 32'd7), 32'h1);
        count_ones(21, ones); chk("R10 waveform kept", 32'(ones), 32'd9);

        // R7 R8 locked multi-register update
        start_and_check(6, 2, 1'b1, 1'b0, 6);
        wr(2'd3, ctrl_word(1'b1, 1'b1, 1'b1, 1'b0, 1'b1));
        wr(2'd1, 32'd10);
        wr(2'd2, 32'd7);
        wr(2'd3, ctrl_word(1'b1, 1'b1, 1'b0, 1'b1, 1'b1));
        repeat (12) @(negedge clk);
        count_ones(18, ones); chk("R7 old waveform held", 32'(ones), 32'd6);
        rd(2'd1, v); chk("R2 shadow period under lock", v, 32'd10);
        wr(2'd3, ctrl_word(1'b1, 1'b1, 1'b0, 1'b1, 1'b0));
        repeat (12) @(negedge clk);
        count_ones(30, ones); chk("R8 new set committed", 32'(ones), 32'd9);

        // R9 unlocked mid-period duty write waits for the wrap
        start_and_check(8, 3, 1'b1, 1'b0, 1);
        wr_en = 1'b1; addr = 2'd2; wdata = 32'd6;
        @(negedge clk);
        wr_en = 1'b0;
        for (int j = 1; j < 16; j++) begin
            if (j > 1) @(negedge clk);
            chk("R9 waveform", 32'(pwm_out),
                32'(exp_level(j % 8, (j < 8) ? 3 : 6, 1'b1, 1'b0)));
        end

        // R11 stop latency and state
        wr(2'd3, ctrl_word(1'b0, 1'b1, 1'b1, 1'b1, 1'b0));
        @(negedge clk);
        chk("R11 stopped level", 32'(pwm_out), 32'h1);
        rd(2'd0, v); chk("R11 counter cleared", v, 32'h0);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule